// File: doc/BRIEF.md
# Configurable Four-Level Pipeline Register

This block holds four data registers, named R1 to R4, that all sample one shared data input. A 2-bit operation code sets, at every rising clock edge, which registers take new values. The four can act as a single four-deep delay chain (R1 to R2 to R3 to R4), as two two-deep pipes (R1/R2 and R3/R4) that are loaded separately from the same input, or they can all hold.

A 2-bit read select chooses which register is shown on the output through a combinational multiplexer. The read select does not depend on the operation code, so one register can be read in the same cycle that others are written. An active-low output enable gates the output. The released state of a three-state output is modelled here as a data word forced to zero plus a separate valid flag.

A compile-time parameter picks how a partial load treats the second register of a pair. With shifting on (the default), that register takes the old value of the first register. With shifting off, it keeps its value.

Top module: `quad_stage_pipe`

## Requirements
- R1: A synchronous active-high reset clears all four registers to zero at the clock edge where it is sampled high.
- R2: Operation code 2'b00 shifts the whole chain on the edge: the input goes to R1, the old R1 to R2, the old R2 to R3 and the old R3 to R4.
- R3: Operation code 2'b11 leaves all four registers unchanged.
- R4: With PAIR_SHIFT=1, operation code 2'b10 loads the input into R1 and moves the old R1 into R2, while R3 and R4 hold.
- R5: With PAIR_SHIFT=1, operation code 2'b01 loads the input into R3 and moves the old R3 into R4, while R1 and R2 hold.
- R6: With PAIR_SHIFT=0, code 2'b10 loads only R1 and code 2'b01 loads only R3. Every other register keeps its value.
- R7: Read select 2'b00 routes R4 to the output, 2'b01 routes R3, 2'b10 routes R2 and 2'b11 routes R1.
- R8: The output is combinational from the stored registers. Before an edge it shows the value that stands at that moment, whatever operation code is being applied. A new value appears only after the edge.
- R9: While out_en_n is high, dout is zero and dout_vld is low. While out_en_n is low, dout_vld is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Shared data input |
| op | input | 2 | Operation code that picks which registers load |
| rsel | input | 2 | Read select for the output multiplexer |
| out_en_n | input | 1 | Output enable, active low |
| dout | output | DATA_W | Selected register, or zero when released |
| dout_vld | output | 1 | High when the output is driven |

## Verification
Two instances, one with pair shifting on and one with it off, receive the same stimulus. This way any difference seen on codes 01 and 10 can only come from the variant. Directed runs apply each operation code on its own with distinct data words. These runs separate a correct shift from a crossed pair, a skipped stage or a load into the wrong pair. A long random mix of codes, data and read selects follows, and all four registers are swept through the multiplexer after every edge. A read taken just before each edge shows that the output does not run ahead of the clock, and toggling the enable checks the released state.

// File: rtl/qsp_pkg.sv
package qsp_pkg;

    localparam int NUM_STAGES = 4;

    typedef enum logic [1:0] {
        OP_CHAIN = 2'b00,
        OP_LOW_PAIR = 2'b01,
        OP_HIGH_PAIR = 2'b10,
        OP_FREEZE = 2'b11
    } qsp_op_e;

    typedef struct packed {
        logic [NUM_STAGES-1:0] load;
        logic                  r3_take_in;
    } qsp_ctrl_t;

    function automatic logic [1:0] sel_to_index(input logic [1:0] sel);
        return ~sel;
    endfunction

endpackage

// File: rtl/qsp_ctrl.sv
module qsp_ctrl
    import qsp_pkg::*;
#(
    parameter bit PAIR_SHIFT = 1'b1
) (
    input  logic [1:0] op,
    output qsp_ctrl_t  ctrl
);
    qsp_op_e op_e;
    assign op_e = qsp_op_e'(op);

    always_comb begin
        ctrl = '0;
        unique case (op_e)
            OP_CHAIN: ctrl.load = 4'b1111;
            OP_LOW_PAIR: begin
                ctrl.load = PAIR_SHIFT ? 4'b1100 : 4'b0100;
                ctrl.r3_take_in = 1'b1;
            end
            OP_HIGH_PAIR: ctrl.load = PAIR_SHIFT ? 4'b0011 : 4'b0001;
            OP_FREEZE: ctrl.load = 4'b0000;
            default: ctrl.load = 4'b0000;
        endcase
    end
endmodule

// File: rtl/qsp_bank.sv
module qsp_bank
    import qsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [DATA_W-1:0]                   din,
    input  qsp_ctrl_t                           ctrl,
    output logic [NUM_STAGES-1:0][DATA_W-1:0]   regs
);
    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        logic [DATA_W-1:0] nxt;
        if (i == 0) begin : g_head
            assign nxt = din;
        end else if (i == 2) begin : g_mid
            assign nxt = ctrl.r3_take_in ? din : regs[i-1];
        end else begin : g_tail
            assign nxt = regs[i-1];
        end
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (ctrl.load[i])
                regs[i] <= nxt;
        end
    end
endmodule

// File: rtl/qsp_rdmux.sv
module qsp_rdmux
    import qsp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [NUM_STAGES-1:0][DATA_W-1:0] regs,
    input  logic [1:0]                        rsel,
    input  logic                              out_en_n,
    output logic [DATA_W-1:0]                 dout,
    output logic                              dout_vld
);
    logic [DATA_W-1:0] picked;
    assign picked   = regs[sel_to_index(rsel)];
    assign dout_vld = ~out_en_n;
    assign dout     = out_en_n ? '0 : picked;
endmodule

// File: rtl/quad_stage_pipe.sv
module quad_stage_pipe
    import qsp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter bit PAIR_SHIFT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        op,
    input  logic [1:0]        rsel,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);
    qsp_ctrl_t                         ctrl;
    logic [NUM_STAGES-1:0][DATA_W-1:0] regs;

    qsp_ctrl #(.PAIR_SHIFT(PAIR_SHIFT)) u_ctrl (
        .op   (op),
        .ctrl (ctrl)
    );

    qsp_bank #(.DATA_W(DATA_W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .din  (din),
        .ctrl (ctrl),
        .regs (regs)
    );

    qsp_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .regs     (regs),
        .rsel     (rsel),
        .out_en_n (out_en_n),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (regs == '0)); // R1

    AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (op == 2'b00) |=> (regs[0] == $past(din) && regs[1] == $past(regs[0])
                           && regs[2] == $past(regs[1]) && regs[3] == $past(regs[2]))); // R2

    AST_FREEZE_ALL: assert property (@(posedge clk) disable iff (rst)
        (op == 2'b11) |=> $stable(regs)); // R3

    AST_HIGH_PAIR_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op == 2'b10) |=> (regs[0] == $past(din) && $stable(regs[2]) && $stable(regs[3]))); // R4

    AST_LOW_PAIR_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op == 2'b01) |=> (regs[2] == $past(din) && $stable(regs[0]) && $stable(regs[1]))); // R5

    if (PAIR_SHIFT) begin : g_ast_shift
        AST_PAIR_R2_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            (op == 2'b10) |=> (regs[1] == $past(regs[0]))); // R4
        AST_PAIR_R4_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            (op == 2'b01) |=> (regs[3] == $past(regs[2]))); // R5
    end else begin : g_ast_noshift
        AST_PAIR_R2_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (op == 2'b10) |=> $stable(regs[1])); // R6
        AST_PAIR_R4_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (op == 2'b01) |=> $stable(regs[3])); // R6
    end

    AST_SEL_R1: assert property (@(posedge clk) disable iff (rst)
        (!out_en_n && rsel == 2'b11) |-> (dout == regs[0])); // R7
    AST_SEL_R4: assert property (@(posedge clk) disable iff (rst)
        (!out_en_n && rsel == 2'b00) |-> (dout == regs[3])); // R7

    AST_RELEASED: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (!dout_vld && dout == '0)); // R9
endmodule

// File: tb/tb_quad_stage_pipe.sv
`timescale 1ns/100ps
module tb_quad_stage_pipe;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst, out_en_n;
    logic [W-1:0] din;
    logic [1:0] op, rsel;
    logic [W-1:0] dout_a, dout_b;
    logic vld_a, vld_b;

    int checks = 0;
    int failures = 0;

    logic [W-1:0] m_a [4];
    logic [W-1:0] m_b [4];

    always #4 clk = ~clk;

    quad_stage_pipe #(.DATA_W(W), .PAIR_SHIFT(1'b1)) dut (
        .clk(clk), .rst(rst), .din(din), .op(op), .rsel(rsel),
        .out_en_n(out_en_n), .dout(dout_a), .dout_vld(vld_a));

    quad_stage_pipe #(.DATA_W(W), .PAIR_SHIFT(1'b0)) dut_alt (
        .clk(clk), .rst(rst), .din(din), .op(op), .rsel(rsel),
        .out_en_n(out_en_n), .dout(dout_b), .dout_vld(vld_b));

    // index 0 is R1; read select 00 shows R4, 11 shows R1 (R7)
    function automatic int reg_of_sel(input logic [1:0] s);
        case (s)
            2'b00: return 3;
            2'b01: return 2;
            2'b10: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic [1:0] o, input logic [W-1:0] d);
        logic [W-1:0] a [4];
        logic [W-1:0] b [4];
        a = m_a; b = m_b;
        case (o)
            2'b00: begin
                m_a[3] = a[2]; m_a[2] = a[1]; m_a[1] = a[0]; m_a[0] = d;
                m_b[3] = b[2]; m_b[2] = b[1]; m_b[1] = b[0]; m_b[0] = d;
            end
            2'b01: begin
                m_a[3] = a[2]; m_a[2] = d;
                m_b[2] = d;
            end
            2'b10: begin
                m_a[1] = a[0]; m_a[0] = d;
                m_b[0] = d;
            end
            default: ;
        endcase
    endtask

    task automatic sweep(input string req);
        out_en_n = 1'b0;
        for (int s = 0; s < 4; s++) begin
            rsel = 2'(s);
            #0.5;
            check({req, "/R7 default"}, dout_a, m_a[reg_of_sel(rsel)]);
            check({req, "/R7 alt"}, dout_b, m_b[reg_of_sel(rsel)]);
        end
    endtask

    task automatic cycle(input logic [1:0] o, input logic [W-1:0] d, input string req);
        @(negedge clk);
        op = o; din = d; rsel = 2'($urandom_range(0, 3)); out_en_n = 1'b0;
        #1;
        check("R8 pre-edge default", dout_a, m_a[reg_of_sel(rsel)]);
        check("R8 pre-edge alt", dout_b, m_b[reg_of_sel(rsel)]);
        @(posedge clk);
        model_step(o, d);
        #1;
        sweep(req);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; op = 2'b11; din = '0; rsel = '0; out_en_n = 1'b0;
        for (int i = 0; i < 4; i++) begin m_a[i] = '0; m_b[i] = '0; end
        @(posedge clk); @(posedge clk);
        #1;
        sweep("R1 reset");

        @(negedge clk); rst = 1'b0;
        // directed: fill chain with distinct words (R2)
        cycle(2'b00, 8'h11, "R2");
        cycle(2'b00, 8'h22, "R2");
        cycle(2'b00, 8'h33, "R2");
        cycle(2'b00, 8'h44, "R2");
        cycle(2'b11, 8'hEE, "R3");
        cycle(2'b10, 8'hA5, "R4 R6");
        cycle(2'b01, 8'h5A, "R5 R6");
        cycle(2'b10, 8'hC3, "R4 R6");
        cycle(2'b01, 8'h3C, "R5 R6");
        cycle(2'b11, 8'h99, "R3");

        // output released (R9)
        @(negedge clk);
        op = 2'b11;
        for (int s = 0; s < 4; s++) begin
            rsel = 2'(s); out_en_n = 1'b1; #0.5;
            check("R9 released dout", dout_a, '0);
            check("R9 released vld", {7'b0, vld_a}, 8'h00);
            check("R9 released alt vld", {7'b0, vld_b}, 8'h00);
            out_en_n = 1'b0; #0.5;
            check("R9 enabled vld", {7'b0, vld_a}, 8'h01);
        end

        // random mix
        for (int n = 0; n < 400; n++) begin
            cycle(2'($urandom_range(0, 3)), 8'($urandom), "R2-mix");
        end

        // reset mid-run clears (R1)
        @(negedge clk); rst = 1'b1; op = 2'b00; din = 8'hFF;
        @(posedge clk);
        for (int i = 0; i < 4; i++) begin m_a[i] = '0; m_b[i] = '0; end
        #1;
        sweep("R1 midrun");
        @(negedge clk); rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule